// File: doc/BRIEF.md
# Programmable Periodic Pulse Generator

This block makes a repeating rectangular waveform in its own clock domain. Software sets the length of each period and the number of cycles the output stays high. After an enable, a one-cycle start request arms the generator. A programmable start delay then runs, and the waveform begins. The block is placed once per clock domain for each pulser that a measurement system needs: the reference-side and system-side pulsers, their slower trigger pulsers, and a restart pulser.

The narrow form takes a single 32-bit control word. The low half holds the period and the upper bits hold the high time. The wide form serves the restart pulser. It takes its period from the low 24 bits of one word and its high time from the low 23 bits of a second word. A parameter selects the form. Settings are sampled only when a period begins, so the waveform never changes shape part way through a cycle. An illegal high time is clamped so that the output can never stick high.

Top module: `pulse_gen`

## Requirements
- R1: While `rst` is high, and at the first sample after it is released, `pulse` and `pulse_rise` are both low.
- R2: In the narrow form (`WIDE`=0), `cfg_a[15:0]` holds the period in cycles and `cfg_a[30:16]` holds the high time in cycles. `cfg_b` is not used.
- R3: When `start` is sampled high by a clock edge while `enable` is high and the generator is idle, the first `pulse_rise` appears `start_dly`+1 cycles after that edge. `start_dly` ranges from 0 to 15.
- R4: While running, `pulse` is high for counts 0 to H-1 of each period and low for the remaining counts, and each period lasts P cycles.
- R5: `pulse_rise` is high for exactly one cycle, the first cycle of each period that has a nonzero high time, and `pulse` only rises together with it.
- R6: A period value of 0 or 1 holds `pulse` and `pulse_rise` low.
- R7: For a period P of 2 or more, a high time of 0 is used as 1, and a high time of P or more is used as P-1.
- R8: A change to the control words while a period is under way takes effect at the start of the next period. The period that is under way finishes with the old settings.
- R9: When `enable` is low, the block returns to idle at the next edge, so `pulse` is low in the next cycle. A `start` seen while `enable` is low is ignored, and raising `enable` alone does not start the waveform.
- R10: A `start` seen while the generator is already running has no effect on the timing of the waveform.
- R11: In the wide form (`WIDE`=1), `cfg_a[23:0]` holds the period and `cfg_b[22:0]` holds the high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the pulser's domain |
| rst | input | 1 | Synchronous reset, active high |
| cfg_a | input | 32 | Narrow form: period and high time; wide form: period |
| cfg_b | input | 32 | Wide form: high time; unused in the narrow form |
| enable | input | 1 | Low holds the generator idle |
| start | input | 1 | Arms the start delay when the generator is enabled and idle |
| start_dly | input | DLY_W | Extra cycles before the first period (the delay applied is this value plus one) |
| pulse | output | 1 | Periodic waveform |
| pulse_rise | output | 1 | One-cycle strobe at the first cycle of each period |

## Verification
Three kinds of internal state can go wrong, and each shows at the ports. A bad period counter or bad latched period shows as a wrong distance between two `pulse_rise` strobes. This is visible within one period. A bad latched high time or a wrong clamp shows as a wrong count of high cycles after a strobe, or as a waveform that stays high. A bad start-delay counter or a bad idle/armed state moves the first strobe away from `start_dly`+1 cycles. It can also make a waveform appear with no accepted start, which is visible within a few tens of cycles. If a setting is sampled at the wrong time, the period that is under way takes the new shape and does not wait for the next boundary.

// File: rtl/pulse_gen.sv
module pulse_gen #(
  parameter bit WIDE  = 1'b0,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      cfg_a,
  input  logic [31:0]      cfg_b,
  input  logic             enable,
  input  logic             start,
  input  logic [DLY_W-1:0] start_dly,
  output logic             pulse,
  output logic             pulse_rise
);
  localparam int PW = WIDE ? 24 : 16;
  localparam int HW = PW - 1;

  logic [PW-1:0]    per_in, hi_ext, hi_fix;
  logic [HW-1:0]    hi_in;
  logic [PW-1:0]    cnt_q, per_q, hi_q;
  logic [DLY_W-1:0] dcnt_q;
  logic             waiting_q, running_q, wrap;

  generate
    if (WIDE) begin : g_wide
      assign per_in = cfg_a[PW-1:0];
      assign hi_in  = cfg_b[HW-1:0];
    end else begin : g_narrow
      assign per_in = cfg_a[PW-1:0];
      assign hi_in  = cfg_a[PW+HW-1:PW];
    end
  endgenerate

  assign hi_ext = {1'b0, hi_in};
  assign hi_fix = (per_in < PW'(2))     ? '0 :
                  (hi_ext == '0)        ? PW'(1) :
                  (hi_ext >= per_in)    ? per_in - PW'(1) : hi_ext;

  assign wrap = ({1'b0, cnt_q} + (PW+1)'(1)) >= {1'b0, per_q};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      waiting_q <= 1'b0;
      running_q <= 1'b0;
      dcnt_q    <= '0;
      cnt_q     <= '0;
      per_q     <= '0;
      hi_q      <= '0;
    end else if (waiting_q) begin
      if (dcnt_q == '0) begin
        waiting_q <= 1'b0;
        running_q <= 1'b1;
        cnt_q     <= '0;
        per_q     <= per_in;
        hi_q      <= hi_fix;
      end else begin
        dcnt_q <= dcnt_q - DLY_W'(1);
      end
    end else if (running_q) begin
      if (wrap) begin
        cnt_q <= '0;
        per_q <= per_in;
        hi_q  <= hi_fix;
      end else begin
        cnt_q <= cnt_q + PW'(1);
      end
    end else if (start) begin
      waiting_q <= 1'b1;
      dcnt_q    <= start_dly;
    end
  end

  assign pulse      = running_q && (cnt_q < hi_q);
  assign pulse_rise = running_q && (cnt_q == '0) && (hi_q != '0);
endmodule

// File: rtl/pulse_gen_chk.sv
module pulse_gen_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          pulse,
  input logic          pulse_rise,
  input logic [PW-1:0] cnt_q,
  input logic [PW-1:0] per_q,
  input logic [PW-1:0] hi_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !pulse_rise || !$past(rst)); // R1
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst) !enable |=> !pulse); // R9
  AST_RISE_IS_HIGH: assert property (@(posedge clk) disable iff (rst) pulse_rise |-> pulse); // R5
  AST_RISE_MARKED: assert property (@(posedge clk) disable iff (rst) $rose(pulse) |-> pulse_rise); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst) (per_q >= PW'(2)) |-> (cnt_q < per_q)); // R4
  AST_NO_STUCK_HIGH: assert property (@(posedge clk) disable iff (rst) (per_q != '0) |-> (hi_q < per_q)); // R7
  AST_SHORT_PERIOD_LOW: assert property (@(posedge clk) disable iff (rst) (per_q < PW'(2)) |-> !pulse); // R6
endmodule

bind pulse_gen pulse_gen_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .pulse(pulse), .pulse_rise(pulse_rise),
  .cnt_q(cnt_q), .per_q(per_q), .hi_q(hi_q)
);

// File: tb/pulse_gen_test.sv
`timescale 1ns/1ps
module pulse_gen_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] cfg_a = '0, cfg_b = '0, wcfg_a = '0, wcfg_b = '0;
  logic enable = 1'b0, start = 1'b0, wen = 1'b0, wstart = 1'b0;
  logic [3:0] start_dly = '0, wdly = '0;
  logic pulse, pulse_rise, wpulse, wrise;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  pulse_gen #(.WIDE(1'b0)) uut (
    .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .enable(enable), .start(start),
    .start_dly(start_dly), .pulse(pulse), .pulse_rise(pulse_rise));

  pulse_gen #(.WIDE(1'b1)) uut_w (
    .clk(clk), .rst(rst), .cfg_a(wcfg_a), .cfg_b(wcfg_b), .enable(wen), .start(wstart),
    .start_dly(wdly), .pulse(wpulse), .pulse_rise(wrise));

  // period, high time, start delay, expected latency, expected high, expected period
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{10,     5,      0,  1,  5,      10},
    '{7,      3,      3,  4,  3,      7},
    '{2,      1,      15, 16, 1,      2},
    '{12,     0,      2,  3,  1,      12},
    '{6,      9,      1,  2,  5,      6},
    '{6,      6,      0,  1,  5,      6},
    '{16640,  16384,  7,  8,  16384,  16640}
  };

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic period_meas(output int hl, output int pl);
    int g = 0;
    hl = 0;
    while (pulse && g < 70000) begin hl++; g++; @(negedge clk); end
    pl = hl;
    while (!pulse_rise && g < 70000) begin pl++; g++; @(negedge clk); end
  endtask

  task automatic launch(input int d, output int lat);
    @(negedge clk); enable = 1'b1; start_dly = 4'(d); start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 0;
    while (!pulse_rise && lat < 200) begin lat++; @(negedge clk); end
  endtask

  task automatic quiet(input string req, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pulse || pulse_rise) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int lat, hl, pl, g;
    enable = 1'b1; start = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pulse in reset", int'(pulse), 0);
    check("R1 rise in reset", int'(pulse_rise), 0);
    start = 1'b0; enable = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 pulse after reset", int'(pulse), 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk); enable = 1'b0;
      cfg_a = {1'b0, 15'(VEC[v][1]), 16'(VEC[v][0])};
      cfg_b = 32'hFFFF_FFFF;
      launch(VEC[v][2], lat);
      check($sformatf("R3 latency v%0d", v), lat, VEC[v][3]);
      period_meas(hl, pl);
      check($sformatf("R4 R7 R2 high v%0d", v), hl, VEC[v][4]);
      check($sformatf("R4 R2 period v%0d", v), pl, VEC[v][5]);
    end

    // R6: periods 0 and 1 stay low
    @(negedge clk); enable = 1'b0; cfg_a = {1'b0, 15'd0, 16'd1};
    launch(0, lat); quiet("R6 period 1", 40);
    @(negedge clk); enable = 1'b0; cfg_a = {1'b0, 15'd3, 16'd0};
    launch(0, lat); quiet("R6 period 0", 40);

    // R8: change mid-period
    @(negedge clk); enable = 1'b0; cfg_a = {1'b0, 15'd5, 16'd10};
    launch(1, lat);
    period_meas(hl, pl);
    cfg_a = {1'b0, 15'd2, 16'd6};
    period_meas(hl, pl);
    check("R8 old high kept", hl, 5);
    check("R8 old period kept", pl, 10);
    period_meas(hl, pl);
    check("R8 new high", hl, 2);
    check("R8 new period", pl, 6);

    // R10: start while running
    start = 1'b1;
    period_meas(hl, pl);
    start = 1'b0;
    check("R10 period unchanged", pl, 6);
    check("R10 high unchanged", hl, 2);

    // R9: disable, start while disabled, re-enable alone
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R9 low after disable", int'(pulse), 0);
    start = 1'b1; repeat (3) @(negedge clk); start = 1'b0;
    quiet("R9 start ignored when disabled", 20);
    enable = 1'b1;
    quiet("R9 enable alone idle", 30);

    // R11: wide form
    @(negedge clk); wcfg_a = 32'hFF01_0004; wcfg_b = 32'hFF80_0003; wdly = 4'd2;
    wen = 1'b1; wstart = 1'b1;
    @(negedge clk); wstart = 1'b0; lat = 0;
    while (!wrise && lat < 200) begin lat++; @(negedge clk); end
    check("R11 R3 wide latency", lat, 3);
    hl = 0; g = 0;
    while (wpulse && g < 70000) begin hl++; g++; @(negedge clk); end
    pl = hl;
    while (!wrise && g < 70000) begin pl++; g++; @(negedge clk); end
    check("R11 wide high", hl, 3);
    check("R11 wide period", pl, 65540);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule